// File: doc/BRIEF.md
# Interruptible Instruction Repeat Counter

This block sits next to the issue stage of a co-processor. It makes one operation be issued several times in a row. A sequence starts on a start strobe. The count is taken either from a 5-bit immediate in the strobe or from a 13-bit count held in a repeat word that software can read and write. The issuing logic reports each completed execution with a done pulse. The controller answers one cycle later with either a "go again" pulse or a "finished" pulse. The count is tested for zero before it is decremented, so a stored count of N gives N+1 executions. An immediate value V is loaded as V-1.

An interrupt can park a running sequence through a suspend/resume handshake. While parked, the active flag stays set and the count keeps the remaining executions minus one. Software may save and restore the count during that time. On resume the controller asks for the next issue at once.

Start requests that would corrupt a sequence are refused and recorded in a sticky error bit. These are a start while a sequence is running or parked, and a stored-count start in the slot directly after a count write.

Top module: `rpt_ctrl`

## Requirements
- R1: After a synchronous reset, the controller is idle with count 0. The active flag, suspended indication, error bit, again pulse and finish pulse are all 0.
- R2: A start from the stored count N (start_src_i=1) loads N and sets active. Each of the first N done pulses gives an again_o pulse one cycle later. The (N+1)-th done pulse gives a finish_o pulse instead. again_o and finish_o are never high together.
- R3: A start from the immediate (start_src_i=0) with value V loads V-1 into the count. A value of 0 is treated like 1: it loads 0 and gives a single execution.
- R4: A done pulse while running with a non-zero count lowers the count by one in the next cycle. With a zero count, the count stays 0.
- R5: The active flag rises in the cycle after an accepted start. It stays high until the cycle that carries the finish pulse, and falls in exactly that cycle.
- R6: A suspend request while running parks the sequence: suspended_o and active_o are high. While parked, the count is held and done pulses are ignored. A resume request returns to running and gives an again_o pulse in the next cycle. Resume wins over a simultaneous suspend.
- R7: Suspend arriving with a done pulse on a non-zero count decrements the count and parks, with no again pulse. On a zero count, the sequence finishes and does not park.
- R8: A start while active (running or parked) is ignored: the count and state are unchanged. It sets the sticky error bit. The error bit is cleared only by an accepted write with wr_err_clr_i=1, and setting wins over clearing.
- R9: A write (wr_en_i) while idle loads wr_count_i and leaves active low. A write while parked loads the count and keeps active high. A write while running is ignored.
- R10: A stored-count start in the cycle directly after an accepted write is refused and sets the error bit. An immediate start in that cycle is accepted.
- R11: When a start is accepted in the same cycle as a write, the start takes effect and the write is dropped.
- R12: word_o shows the repeat word: bit 15 = active, bit 14 = error, bit 13 = 0, bits 12:0 = count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request strobe |
| start_src_i | input | 1 | 1 = stored count, 0 = immediate |
| start_imm_i | input | 5 | Immediate execution count |
| done_i | input | 1 | One execution of the operation completed |
| susp_i | input | 1 | Interrupt suspend request |
| resume_i | input | 1 | Interrupt end, resume request |
| wr_en_i | input | 1 | Repeat word write strobe |
| wr_count_i | input | 13 | Count value to write |
| wr_err_clr_i | input | 1 | Clear the error bit with this write |
| again_o | output | 1 | Issue the operation again (pulse) |
| finish_o | output | 1 | Sequence complete (pulse) |
| active_o | output | 1 | Repeat-active flag |
| suspended_o | output | 1 | Sequence parked by an interrupt |
| err_o | output | 1 | Sticky refused-start error |
| count_o | output | 13 | Current repeat count |
| word_o | output | 16 | Repeat word read view |

## Verification
Every result is registered: count, flag, error bit, suspended indication and both pulses take the inputs present before a rising edge and show them just after that edge. The bench drives a whole cycle of inputs after a falling edge and advances its own model of the requirements by one step. It lets one rising edge pass, then compares every output at the following falling edge. As a result, each comparison sees the response due exactly one cycle after its stimulus, and never a value still settling at the edge.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } rpt_state_e;
endpackage

// File: rtl/rpt_start_dec.sv
module rpt_start_dec #(
  parameter int CNT_W = 13,
  parameter int IMM_W = 5
) (
  input  logic             start_i,
  input  logic             src_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [CNT_W-1:0] stored_i,
  input  logic             busy_i,
  input  logic             wr_last_i,
  output logic             accept_o,
  output logic             reject_o,
  output logic [CNT_W-1:0] load_o
);
  localparam int PAD_W = CNT_W - IMM_W;

  logic [IMM_W-1:0] imm_m1;

  always_comb begin
    imm_m1   = (imm_i == '0) ? '0 : imm_i - 1'b1;
    reject_o = start_i & (busy_i | (src_i & wr_last_i));
    accept_o = start_i & ~reject_o;
    load_o   = src_i ? stored_i : {{PAD_W{1'b0}}, imm_m1};
  end
endmodule

// File: rtl/rpt_count.sv
module rpt_count #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (dec_i)  cnt_o <= cnt_o - 1'b1;
    else if (wr_i)   cnt_o <= wr_val_i;
  end

  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/rpt_seq.sv
module rpt_seq
  import rpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept_i,
  input  logic       done_i,
  input  logic       zero_i,
  input  logic       susp_i,
  input  logic       resume_i,
  output rpt_state_e state_o,
  output logic       dec_o,
  output logic       again_o,
  output logic       fin_o
);
  rpt_state_e nxt;
  logic again_n, fin_n;

  always_comb begin
    nxt     = state_o;
    dec_o   = 1'b0;
    again_n = 1'b0;
    fin_n   = 1'b0;
    unique case (state_o)
      ST_IDLE: if (accept_i) nxt = ST_RUN;
      ST_RUN: begin
        if (done_i) begin
          if (zero_i) begin
            fin_n = 1'b1;
            nxt   = ST_IDLE;
          end else begin
            dec_o = 1'b1;
            if (susp_i) nxt = ST_SUSP;
            else        again_n = 1'b1;
          end
        end else if (susp_i) begin
          nxt = ST_SUSP;
        end
      end
      ST_SUSP: if (resume_i) begin
        nxt     = ST_RUN;
        again_n = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= ST_IDLE;
      again_o <= 1'b0;
      fin_o   <= 1'b0;
    end else begin
      state_o <= nxt;
      again_o <= again_n;
      fin_o   <= fin_n;
    end
  end
endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int IMM_W  = 5,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              start_src_i,
  input  logic [IMM_W-1:0]  start_imm_i,
  input  logic              done_i,
  input  logic              susp_i,
  input  logic              resume_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_count_i,
  input  logic              wr_err_clr_i,
  output logic              again_o,
  output logic              finish_o,
  output logic              active_o,
  output logic              suspended_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int GAP_W = WORD_W - CNT_W - 2;

  rpt_state_e       state;
  logic             accept, reject, dec, zero, wr_ok, wr_last;
  logic [CNT_W-1:0] load_val;

  rpt_start_dec #(.CNT_W(CNT_W), .IMM_W(IMM_W)) u_dec (
    .start_i  (start_i),
    .src_i    (start_src_i),
    .imm_i    (start_imm_i),
    .stored_i (count_o),
    .busy_i   (state != ST_IDLE),
    .wr_last_i(wr_last),
    .accept_o (accept),
    .reject_o (reject),
    .load_o   (load_val)
  );

  rpt_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .accept_i(accept),
    .done_i  (done_i),
    .zero_i  (zero),
    .susp_i  (susp_i),
    .resume_i(resume_i),
    .state_o (state),
    .dec_o   (dec),
    .again_o (again_o),
    .fin_o   (finish_o)
  );

  assign wr_ok = wr_en_i & ~accept & (state != ST_RUN);

  rpt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load_i    (accept),
    .load_val_i(load_val),
    .dec_i     (dec),
    .wr_i      (wr_ok),
    .wr_val_i  (wr_count_i),
    .cnt_o     (count_o),
    .zero_o    (zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o   <= 1'b0;
      wr_last <= 1'b0;
    end else begin
      wr_last <= wr_ok;
      if (reject)                     err_o <= 1'b1;
      else if (wr_ok && wr_err_clr_i) err_o <= 1'b0;
    end
  end

  assign active_o    = (state != ST_IDLE);
  assign suspended_o = (state == ST_SUSP);
  assign word_o      = {active_o, err_o, {GAP_W{1'b0}}, count_o};
endmodule

// File: rtl/rpt_ctrl_chk.sv
module rpt_ctrl_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             wr_en_i,
  input logic             wr_err_clr_i,
  input logic             again_o,
  input logic             finish_o,
  input logic             active_o,
  input logic             suspended_o,
  input logic             err_o,
  input logic [CNT_W-1:0] count_o
);
  // R2
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(again_o && finish_o));

  // R5
  flag_falls_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active_o) |-> finish_o);

  // R5
  finish_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    finish_o |-> !active_o);

  // R6
  parked_count_held_chk: assert property (@(posedge clk) disable iff (rst)
    (suspended_o && !wr_en_i) |=> $stable(count_o));

  // R6
  again_only_running_chk: assert property (@(posedge clk) disable iff (rst)
    again_o |-> (active_o && !suspended_o));

  // R8
  busy_start_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && active_o) |=> err_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o && !(wr_en_i && wr_err_clr_i)) |=> err_o);
endmodule

bind rpt_ctrl rpt_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .wr_en_i     (wr_en_i),
  .wr_err_clr_i(wr_err_clr_i),
  .again_o     (again_o),
  .finish_o    (finish_o),
  .active_o    (active_o),
  .suspended_o (suspended_o),
  .err_o       (err_o),
  .count_o     (count_o)
);

// File: tb/rpt_ctrl_test.sv
`timescale 1ns/1ps
module rpt_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start, src, done, susp, resume, wr, wr_clr;
  logic [4:0]  imm;
  logic [12:0] wr_cnt;
  logic again_o, finish_o, active_o, suspended_o, err_o;
  logic [12:0] count_o;
  logic [15:0] word_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench model of the requirements
  int          m_st;   // 0 idle, 1 running, 2 parked
  logic [12:0] m_cnt;
  logic        m_err, m_wrlast, m_again, m_fin;

  always #10 clk = ~clk;

  rpt_ctrl uut (
    .clk(clk), .rst(rst), .start_i(start), .start_src_i(src), .start_imm_i(imm),
    .done_i(done), .susp_i(susp), .resume_i(resume), .wr_en_i(wr),
    .wr_count_i(wr_cnt), .wr_err_clr_i(wr_clr), .again_o(again_o),
    .finish_o(finish_o), .active_o(active_o), .suspended_o(suspended_o),
    .err_o(err_o), .count_o(count_o), .word_o(word_o)
  );

  function automatic logic [12:0] imm_load(input logic [4:0] v);
    return (v == 5'd0) ? 13'd0 : {8'd0, v} - 13'd1;
  endfunction

  task automatic model_reset();
    m_st = 0; m_cnt = '0; m_err = 0; m_wrlast = 0; m_again = 0; m_fin = 0;
  endtask

  task automatic model_step();
    bit rej, acc, wok;
    rej = start && ((m_st != 0) || (src && m_wrlast));
    acc = start && !rej;
    wok = wr && !acc && (m_st != 1);
    m_again = 0; m_fin = 0;
    if (acc) begin
      m_cnt = src ? m_cnt : imm_load(imm);
      m_st  = 1;
    end else if (m_st == 1) begin
      if (done) begin
        if (m_cnt == 0) begin m_fin = 1; m_st = 0; end
        else begin
          m_cnt = m_cnt - 1;
          if (susp) m_st = 2; else m_again = 1;
        end
      end else if (susp) m_st = 2;
    end else if (m_st == 2) begin
      if (resume) begin m_st = 1; m_again = 1; end
    end
    if (wok) m_cnt = wr_cnt;
    if (rej) m_err = 1;
    else if (wok && wr_clr) m_err = 0;
    m_wrlast = wok;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5 active", active_o, m_st != 0);
    chk("R6 suspended", suspended_o, m_st == 2);
    chk("R4 count", count_o, m_cnt);
    chk("R2 again", again_o, m_again);
    chk("R2 finish", finish_o, m_fin);
    chk("R8 err", err_o, m_err);
    chk("R12 word", word_o, {m_st != 0, m_err, 1'b0, m_cnt});
  endtask

  task automatic idle_inputs();
    start = 0; src = 0; imm = '0; done = 0; susp = 0; resume = 0;
    wr = 0; wr_cnt = '0; wr_clr = 0;
  endtask

  // inputs are set before calling; one edge, compare at the falling edge
  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic do_start(input logic s, input logic [4:0] v);
    start = 1; src = s; imm = v; cycle();
  endtask

  task automatic do_done(); done = 1; cycle(); endtask

  task automatic do_write(input logic [12:0] v, input logic clr);
    wr = 1; wr_cnt = v; wr_clr = clr; cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 flags", {active_o, suspended_o, err_o, again_o, finish_o}, 0);

    // R2 stored count 2 -> three executions
    do_write(13'd2, 0);
    cycle();                       // spacer slot
    do_start(1, 0);
    chk("R2 loaded", count_o, 2);
    do_done(); chk("R2 first again", again_o, 1);
    do_done(); chk("R4 count 0", count_o, 0);
    do_done(); chk("R2 finish third", finish_o, 1);
    chk("R5 flag clear at finish", active_o, 0);

    // R3 immediate 24 -> count 23; immediate 0 -> single execution
    do_start(0, 5'd24);
    chk("R3 imm minus one", count_o, 23);
    susp = 1; cycle();             // R6 park
    chk("R6 parked", suspended_o, 1);
    do_done();
    chk("R6 done ignored", count_o, 23);
    do_start(0, 5'd3);
    chk("R8 start while parked", err_o, 1);
    chk("R8 count unchanged", count_o, 23);
    do_write(13'd1, 1);            // R9 restore while parked
    chk("R9 parked write count", count_o, 1);
    chk("R9 parked keeps flag", active_o, 1);
    chk("R8 err cleared", err_o, 0);
    resume = 1; susp = 1; cycle();
    chk("R6 resume again", again_o, 1);
    chk("R6 resume wins", suspended_o, 0);
    do_write(13'd7, 0);
    chk("R9 run write ignored", count_o, 1);
    done = 1; susp = 1; cycle();   // R7 decrement and park
    chk("R7 parked after dec", {suspended_o, again_o, count_o}, {1'b1, 1'b0, 13'd0});
    resume = 1; cycle();
    done = 1; susp = 1; cycle();   // R7 final done wins over suspend
    chk("R7 finish not park", {finish_o, suspended_o, active_o}, 3'b100);

    do_start(0, 5'd0);
    chk("R3 imm zero count", count_o, 0);
    do_done();
    chk("R3 imm zero single", finish_o, 1);

    // R10 stored start right after a write is refused
    do_write(13'd5, 0);
    do_start(1, 0);
    chk("R10 refused", {active_o, err_o}, 2'b01);
    do_write(13'd4, 1);
    do_start(0, 5'd9);
    chk("R10 imm accepted", {active_o, count_o}, {1'b1, 13'd8});
    susp = 1; cycle();
    do_write(13'd0, 0); resume = 1; cycle();
    do_done(); chk("R4 done at zero", finish_o, 1);

    // R11 start with same-cycle write
    start = 1; src = 0; imm = 5'd2; wr = 1; wr_cnt = 13'd99; cycle();
    chk("R11 start wins", count_o, 1);
    do_done(); do_done();
    chk("R11 done", active_o, 0);

    // random mix
    void'($urandom(32'd7));
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      start  = (r < 8);
      src    = $urandom_range(0, 1);
      imm    = 5'($urandom_range(0, 31));
      done   = ($urandom_range(0, 99) < 55);
      susp   = ($urandom_range(0, 99) < 6);
      resume = ($urandom_range(0, 99) < 30);
      wr     = ($urandom_range(0, 99) < 7);
      wr_cnt = 13'($urandom_range(0, 20));
      wr_clr = $urandom_range(0, 1);
      cycle();
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule